// File: doc/BRIEF.md
# Multi-Mode Per-Channel Scaler Bank

The block holds one counter for each of a set of input channels. All of them run on one sampling clock, 200 MHz in the target system. Each channel's input first passes through a two-stage synchronizer. It then goes through an optional per-channel polarity inversion. After that it feeds a counter that works in one of two ways:

- **Edge mode:** the counter adds one for every rising edge of the conditioned input.
- **Duty-cycle mode:** the counter adds one for every sampling clock cycle in which the conditioned input is high.

A per-channel live-time option stops counting while an external, synchronized busy signal from the data-acquisition system is asserted. The counters then accumulate only while the system is able to take data.

Software-facing control is a small register port:

- **Mode write:** a channel address, a write enable and a 3-bit mode word set the inversion, the counting mode and the live-time gating of the addressed channel.
- **Snapshot:** a single strobe copies every counter and overflow flag into shadow registers in the same cycle. Values read afterwards are therefore coherent across channels. When the clear-on-latch input is set together with the strobe, the live counters restart in that same cycle and no count is lost.
- **Clear:** a separate strobe clears all live counters and flags.
- **Read:** the shadow value of the addressed channel appears on the read port one cycle after the address is presented.

Counters saturate at all ones. A sticky overflow flag records lost counts.

Top module: `multi_mode_scaler_bank`

## Requirements
- R1: After reset every counter, shadow register, overflow flag, read output and mode word is zero. Mode word zero means edge mode, no inversion and no live-time gating.
- R2: A cycle with `regWrEn` high loads `regWrData` into the mode word of channel `regAddr` and clears that channel's counter and overflow flag. Other channels are unaffected. The mode word bits are: bit 0 invert, bit 1 duty-cycle mode, bit 2 live-time gating.
- R3: In edge mode the counter adds exactly one for each rising edge of the synchronized, conditioned input. A pulse that is high for at least one sampling period and is separated by at least one low period is never lost. The counter never advances by more than one per cycle.
- R4: In duty-cycle mode the counter adds one for each sampling clock cycle in which the conditioned input is high.
- R5: With the invert bit set, the channel counts the input's falling edges in edge mode. Changing the polarity never creates a spurious count.
- R6: With the live-time bit set, no count is added while the synchronized busy input is high. With the bit clear, busy has no effect.
- R7: A cycle with `latchStb` high copies every channel's counter and overflow flag into its shadow registers at once. The shadows hold until the next latch.
- R8: When `clearOnLatch` is high together with `latchStb`, each counter restarts from that cycle's own increment (0 or 1), so the sum of successive snapshots loses no count.
- R9: A cycle with `clearStb` high sets every counter and overflow flag to zero. It takes priority over a concurrent increment, mode write or latch restart.
- R10: A counter at all ones stays there. An increment arriving at all ones sets the channel's overflow flag, which stays set until the channel is cleared. `rdOvf` shows the latched flag.
- R11: `rdData` and `rdOvf` show the shadow registers of the channel addressed by `regAddr` one clock cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanIn | input | NUM_CH | Asynchronous channel inputs |
| busyIn | input | 1 | Asynchronous acquisition busy signal |
| regAddr | input | ADDR_W | Channel address for mode write and read |
| regWrEn | input | 1 | Mode word write enable |
| regWrData | input | 3 | Mode word: bit 0 invert, bit 1 duty-cycle mode, bit 2 live-time gating |
| latchStb | input | 1 | Snapshot all counters into shadows |
| clearOnLatch | input | 1 | Restart live counters with the snapshot |
| clearStb | input | 1 | Clear all counters and overflow flags |
| rdData | output | CNT_W | Latched count of the addressed channel |
| rdOvf | output | 1 | Latched overflow flag of the addressed channel |

## Verification
The snapshot-with-restart and the counting increment can fall in the same cycle. Any count that arrives on the latch edge must land either in the snapshot or in the restarted counter, never in both and never in neither. The bench holds a channel high in duty-cycle mode and issues two latches exactly ten cycles apart, the first with restart. It judges the second snapshot against exactly ten. The same window opened by a clear strobe instead must yield nine, because a clear discards the increment of its own cycle.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  localparam int MODE_W = 3;

  // Per-channel mode word; bit 0 invert, bit 1 duty, bit 2 live gating
  typedef struct packed {
    logic liveGate;
    logic dutyMode;
    logic invert;
  } chanMode_t;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic latch;
    logic restartOnLatch;
    logic clearAll;
  } ctrlStrobes_t;
endpackage

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
  import scaler_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWrEn,
  input  logic [MODE_W-1:0]        regWrData,
  input  logic                     latchStb,
  input  logic                     clearOnLatch,
  input  logic                     clearStb,
  output chanMode_t [NUM_CH-1:0]   modeVec,
  output logic [NUM_CH-1:0]        modeClr,
  output ctrlStrobes_t             strobes
);
  chanMode_t modeReg [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
    assign modeClr[ch] = regWrEn && (int'(regAddr) == ch);
    assign modeVec[ch] = modeReg[ch];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < NUM_CH; ch++) modeReg[ch] <= '0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++)
        if (modeClr[ch]) modeReg[ch] <= chanMode_t'(regWrData);
    end
  end

  assign strobes.latch          = latchStb;
  assign strobes.restartOnLatch = latchStb && clearOnLatch;
  assign strobes.clearAll       = clearStb;
endmodule

// File: rtl/scaler_channel.sv
module scaler_channel
  import scaler_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawBit,
  input  logic             busySync,
  input  chanMode_t        mode,
  input  ctrlStrobes_t     strobes,
  input  logic             modeClr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic [CNT_W-1:0] shadowCnt,
  output logic             shadowOvf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic prevRaw;
  logic condNow, condPrev, gated, inc;

  // Same inversion on both samples: a polarity change never forms an edge
  assign condNow  = rawBit ^ mode.invert;
  assign condPrev = prevRaw ^ mode.invert;
  assign gated    = mode.liveGate && busySync;
  assign inc      = !gated && (mode.dutyMode ? condNow : (condNow && !condPrev));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRaw   <= 1'b0;
      cnt       <= '0;
      ovf       <= 1'b0;
      shadowCnt <= '0;
      shadowOvf <= 1'b0;
    end else begin
      prevRaw <= rawBit;
      if (strobes.latch) begin
        shadowCnt <= cnt;
        shadowOvf <= ovf;
      end
      if (strobes.clearAll || modeClr) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (strobes.restartOnLatch) begin
        cnt <= CNT_W'(inc);
        ovf <= 1'b0;
      end else if (inc) begin
        if (cnt == CNT_MAX) ovf <= 1'b1;
        else                cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scaler_datapath.sv
module scaler_datapath
  import scaler_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      chanIn,
  input  logic                   busyIn,
  input  chanMode_t [NUM_CH-1:0] modeVec,
  input  logic [NUM_CH-1:0]      modeClr,
  input  ctrlStrobes_t           strobes,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [CNT_W-1:0]       rdData,
  output logic                   rdOvf
);
  localparam int SYNC_W = NUM_CH + 1;

  logic [SYNC_W-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_CH-1:0] rawSync;
  logic              busySync;
  logic [CNT_W-1:0]  cntArr    [NUM_CH];
  logic [CNT_W-1:0]  shadowArr [NUM_CH];
  logic [NUM_CH-1:0] ovfVec, shadowOvfVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
    end else begin
      syncPipe[0] <= {busyIn, chanIn};
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign rawSync  = syncPipe[SYNC_STAGES-1][NUM_CH-1:0];
  assign busySync = syncPipe[SYNC_STAGES-1][NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    scaler_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .rawBit    (rawSync[ch]),
      .busySync  (busySync),
      .mode      (modeVec[ch]),
      .strobes   (strobes),
      .modeClr   (modeClr[ch]),
      .cnt       (cntArr[ch]),
      .ovf       (ovfVec[ch]),
      .shadowCnt (shadowArr[ch]),
      .shadowOvf (shadowOvfVec[ch])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdOvf  <= 1'b0;
    end else if (int'(rdAddr) < NUM_CH) begin
      rdData <= shadowArr[rdAddr];
      rdOvf  <= shadowOvfVec[rdAddr];
    end else begin
      rdData <= '0;
      rdOvf  <= 1'b0;
    end
  end

  // Live counters are observed only by the bound checkers
  logic unusedLive;
  always_comb begin
    unusedLive = ^ovfVec;
    for (int ch = 0; ch < NUM_CH; ch++) unusedLive = unusedLive ^ (^cntArr[ch]);
  end
endmodule

// File: rtl/multi_mode_scaler_bank.sv
module multi_mode_scaler_bank
  import scaler_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanIn,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [MODE_W-1:0] regWrData,
  input  logic              latchStb,
  input  logic              clearOnLatch,
  input  logic              clearStb,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdOvf
);
  chanMode_t [NUM_CH-1:0] modeVec;
  logic [NUM_CH-1:0]      modeClr;
  ctrlStrobes_t           strobes;

  scaler_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regAddr      (regAddr),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .latchStb     (latchStb),
    .clearOnLatch (clearOnLatch),
    .clearStb     (clearStb),
    .modeVec      (modeVec),
    .modeClr      (modeClr),
    .strobes      (strobes)
  );

  scaler_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .chanIn  (chanIn),
    .busyIn  (busyIn),
    .modeVec (modeVec),
    .modeClr (modeClr),
    .strobes (strobes),
    .rdAddr  (regAddr),
    .rdData  (rdData),
    .rdOvf   (rdOvf)
  );
endmodule

// File: rtl/scaler_checker.sv
module scaler_chan_checker
  import scaler_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busySync,
  input chanMode_t        mode,
  input ctrlStrobes_t     strobes,
  input logic             modeClr,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic [CNT_W-1:0] shadowCnt,
  input logic             shadowOvf
);
  logic anyClear;
  assign anyClear = strobes.clearAll || modeClr || strobes.restartOnLatch;

  // R3: without a clear the count holds or advances by exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    !anyClear |=> ({1'b0, cnt} == {1'b0, $past(cnt)}) ||
                  ({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1));

  p_busy_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode.liveGate && busySync && !anyClear) |=> $stable(cnt));

  p_mode_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeClr |=> (cnt == '0) && !ovf);

  p_snapshot_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latch |=> (shadowCnt == $past(cnt)) && (shadowOvf == $past(ovf)));

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latch |=> $stable(shadowCnt) && $stable(shadowOvf));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.restartOnLatch && !strobes.clearAll && !modeClr) |=>
      ({1'b0, cnt} <= {{CNT_W{1'b0}}, 1'b1}) && !ovf);

  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (cnt == '0) && !ovf);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (cnt == '1));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !anyClear) |=> ovf);
endmodule

module scaler_top_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] modeClr
);
  // R2: a mode write addresses at most one channel
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(modeClr));
endmodule

bind scaler_channel scaler_chan_checker #(.CNT_W(CNT_W)) u_chanChk (.*);

bind multi_mode_scaler_bank scaler_top_checker #(.NUM_CH(NUM_CH)) u_topChk (
  .clk(clk), .rstN(rstN), .modeClr(modeClr)
);

// File: tb/multi_mode_scaler_bank_bench.sv
`timescale 1ns/1ps
module multi_mode_scaler_bank_bench;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 32;
  localparam int SAT_W  = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] chanIn = '0;
  logic              busyIn = 1'b0;
  logic [1:0]        regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [2:0]        regWrData = '0;
  logic              latchStb = 1'b0;
  logic              clearOnLatch = 1'b0;
  logic              clearStb = 1'b0;
  logic [CNT_W-1:0]  rdData;
  logic              rdOvf;
  logic [SAT_W-1:0]  satData;
  logic              satOvf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  multi_mode_scaler_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_multi_mode_scaler_bank (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .busyIn(busyIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .latchStb(latchStb),
    .clearOnLatch(clearOnLatch), .clearStb(clearStb), .rdData(rdData), .rdOvf(rdOvf)
  );

  // Narrow copy used only to reach saturation in a short run
  multi_mode_scaler_bank #(.NUM_CH(NUM_CH), .CNT_W(SAT_W)) u_sat (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .busyIn(busyIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .latchStb(latchStb),
    .clearOnLatch(clearOnLatch), .clearStb(clearStb), .rdData(satData), .rdOvf(satOvf)
  );

  typedef struct packed {
    logic [2:0] mode;   // bit0 invert, bit1 duty, bit2 live
    logic       busy;
    int         n;
    int         w;
    int         gap;
    int         expCnt;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 5, 1, 1, 5},   // R3 densest pulse train
    '{3'b000, 1'b0, 3, 4, 2, 3},   // R3 wide pulses count once
    '{3'b010, 1'b0, 4, 3, 2, 12},  // R4 high cycles
    '{3'b010, 1'b0, 6, 1, 1, 6},   // R4 single-cycle pulses
    '{3'b001, 1'b0, 4, 2, 3, 4},   // R5 inverted edge counting
    '{3'b100, 1'b1, 5, 1, 2, 0},   // R6 busy inhibits
    '{3'b100, 1'b0, 5, 1, 2, 5},   // R6 live but not busy
    '{3'b000, 1'b1, 5, 1, 2, 5},   // R6 busy ignored without live bit
    '{3'b110, 1'b1, 3, 4, 1, 0}    // R6 duty gated
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input longint got, input longint expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic writeMode(input int ch, input logic [2:0] m);
    regAddr = 2'(ch); regWrData = m; regWrEn = 1'b1;
    cyc(1);
    regWrEn = 1'b0;
  endtask

  task automatic clearAllCnt();
    clearStb = 1'b1; cyc(1); clearStb = 1'b0;
  endtask

  task automatic doLatch(input logic restart);
    latchStb = 1'b1; clearOnLatch = restart;
    cyc(1);
    latchStb = 1'b0; clearOnLatch = 1'b0;
  endtask

  task automatic pulses(input logic [NUM_CH-1:0] mask, input int n, input int w, input int gap);
    for (int k = 0; k < n; k++) begin
      chanIn = chanIn | mask; cyc(w);
      chanIn = chanIn & ~mask; cyc(gap);
    end
  endtask

  task automatic readCh(input int ch);
    regAddr = 2'(ch); cyc(1);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 rdData after reset", rdData, 0);
    chk("R1 rdOvf after reset", rdOvf, 0);
    doLatch(1'b0);
    readCh(2);
    chk("R1 counter zero after reset", rdData, 0);

    // Table walk on channel 0
    for (int i = 0; i < NV; i++) begin
      busyIn = VECS[i].busy;
      cyc(3);
      writeMode(0, VECS[i].mode);
      clearAllCnt();
      pulses(4'b0001, VECS[i].n, VECS[i].w, VECS[i].gap);
      cyc(4);
      doLatch(1'b0);
      readCh(0);
      chk($sformatf("table row %0d (R3..R6 per row)", i), rdData, VECS[i].expCnt);
      busyIn = 1'b0;
    end

    // R7 coherent snapshot across channels, shadows hold
    writeMode(0, 3'b000);
    writeMode(1, 3'b010);
    clearAllCnt();
    pulses(4'b0011, 3, 2, 2);
    cyc(4);
    doLatch(1'b0);
    pulses(4'b0011, 2, 2, 2);
    cyc(4);
    readCh(0);
    chk("R7 ch0 snapshot held", rdData, 3);
    readCh(1);
    chk("R7 ch1 snapshot held", rdData, 6);

    // R2 mode write clears only its own channel
    writeMode(0, 3'b000);
    doLatch(1'b0);
    readCh(0);
    chk("R2 written channel cleared", rdData, 0);
    // R11 read latency: unchanged before the edge, new value after
    regAddr = 2'd1;
    chk("R11 old value before edge", rdData, 0);
    cyc(1);
    chk("R2 other channel kept counting", rdData, 10);

    // R8 restart on latch loses nothing: second window is exactly 10
    writeMode(0, 3'b010);
    clearAllCnt();
    chanIn[0] = 1'b1;
    cyc(5);
    doLatch(1'b1);
    cyc(9);
    doLatch(1'b0);
    readCh(0);
    chk("R8 window after restart", rdData, 10);

    // R9 clear drops its own cycle's increment: window gives 9
    clearAllCnt();
    cyc(9);
    doLatch(1'b0);
    readCh(0);
    chk("R9 window after clear", rdData, 9);
    chanIn[0] = 1'b0;
    cyc(4);

    // R10 saturation on the narrow instance
    clearAllCnt();
    cyc(3);
    chanIn[0] = 1'b1; cyc(63); chanIn[0] = 1'b0;
    cyc(4);
    doLatch(1'b0);
    readCh(0);
    chk("R10 reaches max without flag", satData, 63);
    chk("R10 flag clear at exact max", satOvf, 0);
    chanIn[0] = 1'b1; cyc(5); chanIn[0] = 1'b0;
    cyc(4);
    doLatch(1'b0);
    readCh(0);
    chk("R10 saturated value", satData, 63);
    chk("R10 overflow flag set", satOvf, 1);
    chk("R10 wide instance no overflow", rdOvf, 0);
    chk("R10 wide instance count", rdData, 68);
    clearAllCnt();
    doLatch(1'b0);
    readCh(0);
    chk("R9 clear resets flag", satOvf, 0);
    chk("R9 clear resets count", satData, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule